// File: doc/BRIEF.md
# Dual-Prescaler PWM Channel Pair

This block produces two pulse-width-modulated outputs from one shared clock-conditioning stage. The shared stage picks one of two source clock enables, divides the chosen rate by a power of two, and gates the result. Each channel divides that tick again by its own linear prescaler. It then counts the result through a 16-bit period, compares the count against a 16-bit active-time value, and drives its output at a programmable active level.

Software programs the pair through a flat register port: a write strobe with address and data, and a read address whose data comes back one cycle later. A channel runs only while its own enable bit and the shared gate are both set. New period and active values are staged, so each output period is generated whole with a single set of values.

Top module: `pwm_pair`

## Requirements
- R1: After reset both outputs are low. Configuration (address 0) reads 0. Both control registers read 0x100 (prescaler 0, active-state 1). Both counters read 0.
- R2: Register map. Address 0 is the clock configuration: source select in bits 1:0, gate in bit 2, divider exponent M in bits 7:4. Address 1 holds the channel enables, bit n for channel n. Addresses 2 and 4 are the channel 0 and 1 controls: prescaler K in bits 7:0, active-state in bit 8. Addresses 3 and 5 are the channel 0 and 1 periods: entire-cycle E in bits 31:16, active-cycle A in bits 15:0. Addresses 6 and 7 are the read-only counters of channels 0 and 1. Read data appears one cycle after the read address.
- R3: An enabled channel repeats a period of E*(K+1)*2^M selected source ticks. Within it, the output is in the active state for A*(K+1)*2^M ticks.
- R4: Source select 0 uses src_ce[0] and 1 uses src_ce[1]. Values 2 and 3 produce no ticks, so the counters hold.
- R5: A divider exponent M above 8 divides by 2^8.
- R6: With active-state 1 the active portion is high and the inactive level low. With active-state 0 both are inverted.
- R7: When a channel's enable bit or the shared gate is clear, its output goes to the inactive level and its counter to 0 within two cycles.
- R8: The counter steps from 0 to E-1 by one per prescaled tick, then wraps to 0. It is readable at all times.
- R9: Period and active values written while a channel runs take effect only from the next wrap. The period in progress completes with the old values.
- R10: A=0 gives a constant inactive output. A>=E gives a constant active output.
- R11: The two channels run concurrently with independent prescaler, period, active and polarity settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_ce | input | 2 | Clock enables of the two selectable sources |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Registered read data |
| pwm_out | output | 2 | Registered PWM outputs, bit n for channel n |

## Verification
The bench builds the block with its default parameters: 16-bit counters, 8-bit prescalers and a maximum exponent of 8. This makes the exponent clamp reachable in a 512-cycle period. The second source runs at half rate, so source selection shows up as a doubled period. Prescaler and divider values are kept small, so every period fits in a few dozen cycles. This leaves room to test the mid-period update, the constant-output corner cases and both polarities in a short run.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int NCH    = 2;
  localparam int ADDR_W = 3;
  localparam int EXP_W  = 4;
  localparam int SEL_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CFG  = 3'd0,
    ADR_EN   = 3'd1,
    ADR_CTL0 = 3'd2,
    ADR_PER0 = 3'd3,
    ADR_CTL1 = 3'd4,
    ADR_PER1 = 3'd5,
    ADR_CNT0 = 3'd6,
    ADR_CNT1 = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic [EXP_W-1:0] exp_m;
    logic             gate;
    logic [SEL_W-1:0] sel;
  } clk_cfg_t;
endpackage

// File: rtl/pwm_clk_stage.sv
module pwm_clk_stage
  import pwm_pair_pkg::*;
#(
  parameter int MAX_EXP = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       src_ce,
  input  logic [SEL_W-1:0] sel,
  input  logic             gate,
  input  logic [EXP_W-1:0] exp_m,
  output logic             tick
);
  localparam int DIV_W = (MAX_EXP < 1) ? 1 : MAX_EXP;

  logic             sel_ce;
  logic [EXP_W-1:0] exp_eff;
  logic [DIV_W-1:0] mask;
  logic [DIV_W-1:0] div_q;
  logic             tick_q;

  always_comb begin
    case (sel)
      2'd0:    sel_ce = src_ce[0];
      2'd1:    sel_ce = src_ce[1];
      default: sel_ce = 1'b0;
    endcase
  end

  always_comb begin
    if (32'(exp_m) > MAX_EXP) exp_eff = EXP_W'(MAX_EXP);
    else                      exp_eff = exp_m;
    mask = ~({DIV_W{1'b1}} << exp_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= gate & sel_ce & ((div_q & mask) == mask);
      if (!gate)       div_q <= '0;
      else if (sel_ce) div_q <= div_q + 1'b1;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic [PSC_W-1:0] psc,
  input  logic             act_hi,
  input  logic [CNT_W-1:0] ent,
  input  logic [CNT_W-1:0] act,
  output logic [CNT_W-1:0] cnt,
  output logic             pwm
);
  logic [PSC_W-1:0] pcnt_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ent_sh;
  logic [CNT_W-1:0] act_sh;
  logic             pwm_q;
  logic             ptick;
  logic             last;
  logic             wrap;

  assign ptick = en & tick & (pcnt_q >= psc);
  assign last  = ({1'b0, cnt_q} + 1'b1) >= {1'b0, ent_sh};
  assign wrap  = ptick & last;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt_q <= '0;
      cnt_q  <= '0;
      ent_sh <= '0;
      act_sh <= '0;
      pwm_q  <= 1'b0;
    end else if (!en) begin
      pcnt_q <= '0;
      cnt_q  <= '0;
      ent_sh <= ent;
      act_sh <= act;
      pwm_q  <= ~act_hi;
    end else begin
      if (tick) pcnt_q <= ptick ? '0 : pcnt_q + 1'b1;
      if (ptick) cnt_q <= last ? '0 : cnt_q + 1'b1;
      if (wrap) begin
        ent_sh <= ent;
        act_sh <= act;
      end
      pwm_q <= (cnt_q < act_sh) ? act_hi : ~act_hi;
    end
  end

  assign cnt = cnt_q;
  assign pwm = pwm_q;

  // R7
  off_level_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pwm_q == !$past(act_hi)) && (cnt_q == '0));
  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (en && ent_sh != '0) |-> (cnt_q < ent_sh));
  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !ptick) |=> $stable(cnt_q));
  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !wrap) |=> $stable(ent_sh) && $stable(act_sh));
  // R10
  zero_act_chk: assert property (@(posedge clk) disable iff (rst)
    (en && act_sh == '0) |=> (pwm_q == !$past(act_hi)));
  // R10
  full_act_chk: assert property (@(posedge clk) disable iff (rst)
    (en && ent_sh != '0 && act_sh >= ent_sh) |=> (pwm_q == $past(act_hi)));
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  input  logic [NCH-1:0][CNT_W-1:0]  cnt,
  output clk_cfg_t                   cfg,
  output logic [NCH-1:0]             chan_en,
  output logic [NCH-1:0][PSC_W-1:0]  psc,
  output logic [NCH-1:0]             act_hi,
  output logic [NCH-1:0][CNT_W-1:0]  ent,
  output logic [NCH-1:0][CNT_W-1:0]  act,
  output logic [DATA_W-1:0]          rd_data
);
  localparam int CTL_W = PSC_W + 1;
  localparam int PER_W = 2 * CNT_W;

  clk_cfg_t                  cfg_q;
  logic [NCH-1:0]            en_q;
  logic [NCH-1:0][CTL_W-1:0] ctl_q;
  logic [NCH-1:0][PER_W-1:0] per_q;
  logic [DATA_W-1:0]         rd_q;
  logic [DATA_W-1:0]         rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      en_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADR_CFG)
        cfg_q <= '{exp_m: wr_data[7:4], gate: wr_data[2], sel: wr_data[1:0]};
      if (wr_addr == ADR_EN)
        en_q <= wr_data[NCH-1:0];
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] CTL_ADR = ADDR_W'(2 + 2 * ch);
    localparam logic [ADDR_W-1:0] PER_ADR = ADDR_W'(3 + 2 * ch);

    always_ff @(posedge clk) begin
      if (rst) begin
        ctl_q[ch] <= CTL_W'(1) << PSC_W;
        per_q[ch] <= '0;
      end else if (wr_en) begin
        if (wr_addr == CTL_ADR) ctl_q[ch] <= wr_data[CTL_W-1:0];
        if (wr_addr == PER_ADR) per_q[ch] <= wr_data[PER_W-1:0];
      end
    end

    assign psc[ch]    = ctl_q[ch][PSC_W-1:0];
    assign act_hi[ch] = ctl_q[ch][PSC_W];
    assign ent[ch]    = per_q[ch][PER_W-1:CNT_W];
    assign act[ch]    = per_q[ch][CNT_W-1:0];
  end

  always_comb begin
    case (rd_addr)
      ADR_CFG:  rd_mux = DATA_W'({cfg_q.exp_m, 1'b0, cfg_q.gate, cfg_q.sel});
      ADR_EN:   rd_mux = DATA_W'(en_q);
      ADR_CTL0: rd_mux = DATA_W'(ctl_q[0]);
      ADR_PER0: rd_mux = DATA_W'(per_q[0]);
      ADR_CTL1: rd_mux = DATA_W'(ctl_q[1]);
      ADR_PER1: rd_mux = DATA_W'(per_q[1]);
      ADR_CNT0: rd_mux = DATA_W'(cnt[0]);
      default:  rd_mux = DATA_W'(cnt[1]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_mux;
  end

  assign cfg     = cfg_q;
  assign chan_en = en_q;
  assign rd_data = rd_q;
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PSC_W   = 8,
  parameter int MAX_EXP = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        src_ce,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NCH-1:0]    pwm_out
);
  clk_cfg_t                  cfg;
  logic [NCH-1:0]            chan_en;
  logic [NCH-1:0][PSC_W-1:0] psc;
  logic [NCH-1:0]            act_hi;
  logic [NCH-1:0][CNT_W-1:0] ent;
  logic [NCH-1:0][CNT_W-1:0] act;
  logic [NCH-1:0][CNT_W-1:0] cnt;
  logic                      tick;

  pwm_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .cnt(cnt), .cfg(cfg), .chan_en(chan_en), .psc(psc),
    .act_hi(act_hi), .ent(ent), .act(act), .rd_data(rd_data)
  );

  pwm_clk_stage #(.MAX_EXP(MAX_EXP)) u_clk (
    .clk(clk), .rst(rst), .src_ce(src_ce), .sel(cfg.sel), .gate(cfg.gate),
    .exp_m(cfg.exp_m), .tick(tick)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    pwm_chan #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chan (
      .clk(clk), .rst(rst), .tick(tick), .en(chan_en[ch] & cfg.gate),
      .psc(psc[ch]), .act_hi(act_hi[ch]), .ent(ent[ch]), .act(act[ch]),
      .cnt(cnt[ch]), .pwm(pwm_out[ch])
    );
  end
endmodule

// File: tb/tb_pwm_pair.sv
module tb_pwm_pair;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        half_q = 1'b0;
  logic [1:0]  src_ce;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [1:0]  pwm_out;
  int checks = 0;
  int errors = 0;

  typedef struct {int ch; int lvl; int per; int hi; string req;} exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;
  always @(negedge clk) half_q <= ~half_q;
  assign src_ce = {half_q, 1'b1};

  pwm_pair dut (
    .clk(clk), .rst(rst), .src_ce(src_ce), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  task automatic chk(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = int'(rd_data);
  endtask

  // assumes the current sample is the first active one
  task automatic pulse_here(input int ch, input int lvl, output int per, output int hi);
    int n;
    n = 0; hi = 0;
    while (int'(pwm_out[ch]) == lvl && n < 5000) begin hi++; n++; @(negedge clk); end
    per = hi;
    while (int'(pwm_out[ch]) != lvl && n < 5000) begin per++; n++; @(negedge clk); end
    if (n >= 5000) per = -1;
  endtask

  task automatic measure(input int ch, input int lvl, output int per, output int hi);
    int n;
    n = 0;
    while (int'(pwm_out[ch]) == lvl && n < 5000) begin n++; @(negedge clk); end
    while (int'(pwm_out[ch]) != lvl && n < 5000) begin n++; @(negedge clk); end
    pulse_here(ch, lvl, per, hi);
  endtask

  task automatic expect_wave(input int ch, input int lvl, input int per, input int hi, input string req);
    exp_t e;
    e.ch = ch; e.lvl = lvl; e.per = per; e.hi = hi; e.req = req;
    sb.push_back(e);
  endtask

  task automatic monitor_drain();
    int p, h;
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      measure(e.ch, e.lvl, p, h);
      measure(e.ch, e.lvl, p, h);
      chk(p == e.per, {e.req, " period"}, p, e.per);
      chk(h == e.hi, {e.req, " active"}, h, e.hi);
    end
  endtask

  task automatic level_run(input int ch, input int lvl, input int cyc, output int bad);
    bad = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (int'(pwm_out[ch]) != lvl) bad++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, v2, p, h, bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(pwm_out == 2'b00, "R1 outputs", int'(pwm_out), 0);
    rd(3'd0, v); chk(v == 0, "R1 cfg", v, 0);
    rd(3'd2, v); chk(v == 32'h100, "R1 ctl0", v, 32'h100);
    rd(3'd4, v); chk(v == 32'h100, "R1 ctl1", v, 32'h100);
    rd(3'd6, v); chk(v == 0, "R1 cnt0", v, 0);

    // R3 basic waveform, src0, M=0, K=0
    wr(3'd0, 32'h04);
    wr(3'd2, 32'h100);
    wr(3'd3, (32'd10 << 16) | 32'd3);
    wr(3'd1, 32'h1);
    expect_wave(0, 1, 10, 3, "R3 base");
    monitor_drain();

    // R3 prescaler and divider; R6/R11 channel 1 active-low concurrently
    wr(3'd0, 32'h14);
    wr(3'd2, 32'h102);
    wr(3'd4, 32'h001);
    wr(3'd5, (32'd8 << 16) | 32'd2);
    wr(3'd1, 32'h3);
    expect_wave(0, 1, 60, 18, "R3 K2M1");
    expect_wave(1, 0, 32, 8, "R6 R11 ch1 low");
    monitor_drain();

    // R4 half-rate source 1
    wr(3'd0, 32'h05);
    wr(3'd2, 32'h100);
    expect_wave(0, 1, 20, 6, "R4 src1");
    monitor_drain();

    // R5 exponent clamp: M=12 behaves as 8
    wr(3'd0, 32'hC4);
    wr(3'd3, (32'd2 << 16) | 32'd1);
    expect_wave(0, 1, 512, 256, "R5 clamp");
    monitor_drain();

    // R10 constant outputs
    wr(3'd0, 32'h04);
    wr(3'd3, (32'd10 << 16) | 32'd0);
    repeat (30) @(negedge clk);
    level_run(0, 0, 200, bad); chk(bad == 0, "R10 A=0", bad, 0);
    wr(3'd3, (32'd10 << 16) | 32'd10);
    repeat (30) @(negedge clk);
    level_run(0, 1, 200, bad); chk(bad == 0, "R10 A=E", bad, 0);
    wr(3'd3, (32'd10 << 16) | 32'd50);
    repeat (30) @(negedge clk);
    level_run(0, 1, 200, bad); chk(bad == 0, "R10 A>E", bad, 0);

    // R9 mid-period update
    wr(3'd3, (32'd10 << 16) | 32'd4);
    measure(0, 1, p, h);
    measure(0, 1, p, h);
    wr_en = 1'b1; wr_addr = 3'd3; wr_data = (32'd20 << 16) | 32'd5;
    h = 1; p = 1;
    @(negedge clk);
    wr_en = 1'b0;
    while (pwm_out[0] == 1'b1 && p < 100) begin h++; p++; @(negedge clk); end
    while (pwm_out[0] == 1'b0 && p < 100) begin p++; @(negedge clk); end
    chk(h == 4, "R9 old active", h, 4);
    chk(p == 10, "R9 old period", p, 10);
    pulse_here(0, 1, p, h);
    chk(h == 5, "R9 new active", h, 5);
    chk(p == 20, "R9 new period", p, 20);

    // R8 counter steps by one per tick
    wr(3'd3, (32'd10 << 16) | 32'd4);
    repeat (40) @(negedge clk);
    @(negedge clk); rd_addr = 3'd6;
    @(negedge clk); v = int'(rd_data);
    @(negedge clk); v2 = int'(rd_data);
    chk(v < 10, "R8 range", v, 9);
    chk(v2 == (v + 1) % 10, "R8 step", v2, (v + 1) % 10);

    // R7 channel disable
    wr(3'd1, 32'h2);
    repeat (2) @(negedge clk);
    chk(pwm_out[0] == 1'b0, "R7 ch0 off level", int'(pwm_out[0]), 0);
    rd(3'd6, v); chk(v == 0, "R7 ch0 cnt", v, 0);
    wr(3'd2, 32'h000);
    repeat (2) @(negedge clk);
    chk(pwm_out[0] == 1'b1, "R6 inverted idle", int'(pwm_out[0]), 1);
    wr(3'd2, 32'h100);

    // R7 gate off stops channel 1
    wr(3'd1, 32'h3);
    repeat (20) @(negedge clk);
    wr(3'd0, 32'h00);
    repeat (2) @(negedge clk);
    chk(pwm_out[1] == 1'b1, "R7 gate ch1 level", int'(pwm_out[1]), 1);
    rd(3'd7, v); chk(v == 0, "R7 gate ch1 cnt", v, 0);

    // R4 reserved select: no ticks, counter holds at 0
    wr(3'd1, 32'h1);
    wr(3'd0, 32'h06);
    repeat (50) @(negedge clk);
    rd(3'd6, v); chk(v == 0, "R4 sel2 cnt", v, 0);
    chk(pwm_out[0] == 1'b1, "R4 sel2 level", int'(pwm_out[0]), 1);

    // R2 readback
    rd(3'd0, v); chk(v == 32'h06, "R2 cfg", v, 32'h06);
    rd(3'd3, v); chk(v == ((10 << 16) | 4), "R2 per0", v, (10 << 16) | 4);
    rd(3'd5, v); chk(v == ((8 << 16) | 2), "R2 per1", v, (8 << 16) | 2);
    rd(3'd1, v); chk(v == 1, "R2 en", v, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule